// File: doc/BRIEF.md
# Memory barrier ordering gate

This block sits between an in-order instruction stream and the load/store issue port of a core. It watches every incoming 32-bit instruction word for the data-memory-barrier encoding. When it finds one, it splits the 4-bit option field into a coherence domain and an access class. While that barrier is open, the block withholds grants from the younger accesses that the class covers. It keeps doing so until the older accesses that the barrier waits on have all been acknowledged.

Outstanding reads and outstanding writes are tracked in two separate counters. A counter goes up on each granted issue and down on each matching completion. When the counters the class cares about both read zero, the barrier retires. In that cycle the stall drops and a single-cycle request carries the domain and class to the interconnect. Only one barrier may be open at a time. A further barrier word that arrives while one is open is held off at the instruction input.

Top module: `mbar_gate`

## Requirements
- R1: A word is a barrier only if bits 31:12 equal 0xD5033 and bits 7:0 equal 0xBF. Any other word, valid or not, leaves grants, stall and the request pulse unchanged.
- R2: The domain output is option bits [3:2] of the word, where option is bits 11:8. The codes are 0 outer, 1 non-shareable, 2 inner and 3 full system.
- R3: The class output is option bits [1:0], where 1 is reads, 2 is writes and 3 is all. A reserved option, with bits [1:0] equal to 0, yields class 3 and domain 3 whatever bits [3:2] hold.
- R4: While a read-class barrier is open, no load or store is granted. It retires once the outstanding-read count is zero, and outstanding writes do not hold it.
- R5: While a write-class barrier is open, stores are not granted and loads are still granted. It retires once the outstanding-write count is zero.
- R6: While an all-class barrier is open, no load or store is granted. It retires once both counts are zero.
- R7: Each count rises by one per grant of its kind and falls by one per completion of its kind. A completion at count zero is ignored. No grant is given while the count of that kind is 15.
- R8: The barrier retires in the first cycle in which its relevant counts are zero. In that cycle stall_o is low, grants follow the requests, and bar_req_o is high for one cycle with the barrier's domain and class.
- R9: While a barrier is open and not retiring, instr_ready_o is low whenever the presented word is a barrier. It is high at every other time.
- R10: While rst_ni is low, both counts are zero, no barrier is open, stall_o and bar_req_o are low and instr_ready_o is high.
- R11: An access granted in the same cycle that a barrier word is accepted counts as older than that barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word valid |
| instr_i | input | 32 | Instruction word |
| instr_ready_o | output | 1 | Instruction input may advance |
| ld_req_i | input | 1 | Load issue request |
| st_req_i | input | 1 | Store issue request |
| ld_gnt_o | output | 1 | Load issue grant |
| st_gnt_o | output | 1 | Store issue grant |
| rd_done_i | input | 1 | A read has completed |
| wr_done_i | input | 1 | A write has completed |
| stall_o | output | 1 | Barrier open and waiting |
| bar_req_o | output | 1 | One-cycle barrier request to the interconnect |
| bar_dom_o | output | 2 | Domain of the retiring barrier |
| bar_cls_o | output | 2 | Access class of the retiring barrier |

## Verification
Grants, instr_ready_o, stall_o and the request pulse are combinational from the current inputs and registered state, so they are due in the same cycle as the stimulus. An accepted barrier word takes effect one cycle later, and a completion first reaches the counts one cycle after it arrives. The bench drives inputs just after the falling edge and compares all outputs against a behavioural model 1 ns later. It then advances the model's integer counts at the rising edge, which keeps every expected value aligned to its register stage.

// File: rtl/mbar_pkg.sv
package mbar_pkg;
  typedef enum logic [1:0] {
    DOM_OUTER = 2'd0,
    DOM_NON   = 2'd1,
    DOM_INNER = 2'd2,
    DOM_SYS   = 2'd3
  } dom_e;

  typedef enum logic [1:0] {
    CLS_RSVD = 2'd0,
    CLS_RD   = 2'd1,
    CLS_WR   = 2'd2,
    CLS_ALL  = 2'd3
  } cls_e;

  localparam logic [19:0] BAR_HI = 20'hD5033;
  localparam logic [7:0]  BAR_LO = 8'hBF;

  localparam int unsigned N_KIND = 2;
  localparam int unsigned K_RD   = 0;
  localparam int unsigned K_WR   = 1;
endpackage

// File: rtl/mbar_decode.sv
module mbar_decode
  import mbar_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic        match_o,
  output dom_e        dom_o,
  output cls_e        cls_o
);
  logic [3:0] opt;

  assign opt     = instr_i[11:8];
  assign match_o = (instr_i[31:12] == BAR_HI) && (instr_i[7:0] == BAR_LO);

  always_comb begin
    dom_o = dom_e'(opt[3:2]);
    cls_o = cls_e'(opt[1:0]);
    if (opt[1:0] == 2'b00) begin
      dom_o = DOM_SYS;
      cls_o = CLS_ALL;
    end
  end
endmodule

// File: rtl/mbar_ctr.sv
module mbar_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         full_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         dec_eff;

  assign dec_eff = dec_i && (cnt_q != '0);
  assign zero_o  = (cnt_q == '0);
  assign full_o  = (cnt_q == MAX);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (inc_i && !dec_eff) cnt_q <= cnt_q + 1'b1;
    else if (!inc_i && dec_eff) cnt_q <= cnt_q - 1'b1;
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !(inc_i && !dec_i));
  // R7
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !inc_i) |=> zero_o);
endmodule

// File: rtl/mbar_gate.sv
module mbar_gate
  import mbar_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        instr_valid_i,
  input  logic [31:0] instr_i,
  output logic        instr_ready_o,
  input  logic        ld_req_i,
  input  logic        st_req_i,
  output logic        ld_gnt_o,
  output logic        st_gnt_o,
  input  logic        rd_done_i,
  input  logic        wr_done_i,
  output logic        stall_o,
  output logic        bar_req_o,
  output logic [1:0]  bar_dom_o,
  output logic [1:0]  bar_cls_o
);
  logic             match;
  dom_e             dec_dom;
  cls_e             dec_cls;
  logic             pend_q;
  dom_e             dom_q;
  cls_e             cls_q;
  logic             retire, active, accept;
  logic             rd_ok, wr_ok;
  logic [N_KIND-1:0] inc, dec, zero, full;
  logic [N_KIND-1:0][CNT_W-1:0] cnt;

  mbar_decode u_dec (
    .instr_i (instr_i),
    .match_o (match),
    .dom_o   (dec_dom),
    .cls_o   (dec_cls)
  );

  assign inc[K_RD] = ld_gnt_o;
  assign inc[K_WR] = st_gnt_o;
  assign dec[K_RD] = rd_done_i;
  assign dec[K_WR] = wr_done_i;

  for (genvar k = 0; k < N_KIND; k++) begin : g_ctr
    mbar_ctr #(.W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[k]),
      .dec_i  (dec[k]),
      .cnt_o  (cnt[k]),
      .zero_o (zero[k]),
      .full_o (full[k])
    );
  end

  assign rd_ok  = (cls_q == CLS_WR) || zero[K_RD];
  assign wr_ok  = (cls_q == CLS_RD) || zero[K_WR];
  assign retire = pend_q && rd_ok && wr_ok;
  assign active = pend_q && !retire;
  assign accept = instr_valid_i && match && !active;

  // loads pass only a write-class barrier
  assign ld_gnt_o = ld_req_i && !(active && cls_q != CLS_WR) && !full[K_RD];
  assign st_gnt_o = st_req_i && !active && !full[K_WR];

  assign instr_ready_o = !(active && match);
  assign stall_o       = active;
  assign bar_req_o     = retire;
  assign bar_dom_o     = dom_q;
  assign bar_cls_o     = cls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dom_q  <= DOM_SYS;
      cls_q  <= CLS_ALL;
    end else if (accept) begin
      pend_q <= 1'b1;
      dom_q  <= dec_dom;
      cls_q  <= dec_cls;
    end else if (retire) begin
      pend_q <= 1'b0;
    end
  end

  // R9
  ready_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_ready_o |-> stall_o);
  // R6
  st_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !st_gnt_o);
  // R5
  wr_bar_ld_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && bar_cls_o == CLS_WR && ld_req_i && cnt[K_RD] != {CNT_W{1'b1}}) |-> ld_gnt_o);
  // R8
  retire_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> bar_req_o);
  // R3
  rsvd_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bar_req_o && bar_cls_o == CLS_RSVD) |-> 1'b0);
endmodule

// File: tb/mbar_gate_tb.sv
module mbar_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iv = 1'b0;
  logic [31:0] iw = '0;
  logic        lq = 1'b0, sq = 1'b0, rd = 1'b0, wd = 1'b0;
  logic        rdy, lg, sg, stl, brq;
  logic [1:0]  bdom, bcls;

  int errors = 0;
  int checks = 0;

  int m_rd = 0, m_wr = 0, m_pend = 0, m_cls = 3, m_dom = 3;

  always #10 clk = ~clk;

  mbar_gate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(iv), .instr_i(iw),
    .instr_ready_o(rdy), .ld_req_i(lq), .st_req_i(sq), .ld_gnt_o(lg),
    .st_gnt_o(sg), .rd_done_i(rd), .wr_done_i(wd), .stall_o(stl),
    .bar_req_o(brq), .bar_dom_o(bdom), .bar_cls_o(bcls)
  );

  function automatic logic [31:0] bw(input logic [3:0] o);
    return {20'hD5033, o, 8'hBF};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic v, input logic [31:0] w,
                     input logic l, input logic s, input logic r, input logic d);
    int e_ret, e_act, e_match, e_ld, e_st, o;
    iv = v; iw = w; lq = l; sq = s; rd = r; wd = d;
    #1;
    e_ret   = m_pend && (m_cls == 2 || m_rd == 0) && (m_cls == 1 || m_wr == 0);
    e_act   = m_pend && !e_ret;
    e_match = (w[31:12] == 20'hD5033) && (w[7:0] == 8'hBF);
    e_ld    = l && !(e_act && m_cls != 2) && (m_rd < 15);
    e_st    = s && !e_act && (m_wr < 15);
    chk("R4 R5 R6 R7 ld_gnt", lg, e_ld);
    chk("R4 R5 R6 R7 st_gnt", sg, e_st);
    chk("R8 stall", stl, e_act);
    chk("R1 R9 instr_ready", rdy, !(e_act && e_match));
    chk("R8 bar_req", brq, e_ret);
    if (e_ret) begin
      chk("R2 bar_dom", bdom, m_dom);
      chk("R3 bar_cls", bcls, m_cls);
    end
    @(posedge clk);
    // R11: grants in the accept cycle count as older
    m_rd = m_rd + e_ld - ((r && m_rd > 0) ? 1 : 0);
    m_wr = m_wr + e_st - ((d && m_wr > 0) ? 1 : 0);
    if (v && e_match && !e_act) begin
      o = w[11:8];
      m_pend = 1;
      if (o[1:0] == 0) begin m_cls = 3; m_dom = 3; end
      else begin m_cls = o[1:0]; m_dom = o[3:2]; end
    end else if (e_ret) m_pend = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 stall", stl, 0);
    chk("R10 bar_req", brq, 0);
    chk("R10 instr_ready", rdy, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: read barrier, non-shareable
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0, 0, 0);
    for (int i = 0; i < 2; i++) cyc(0, '0, 0, 1, 0, 0);
    cyc(1, bw(4'b0101), 1, 1, 0, 0);  // R11 same-cycle grants are older
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, 1, 0, 1);
    for (int i = 0; i < 5; i++) cyc(0, '0, 1, 1, 1, 0);
    idle(2);
    // drain
    for (int i = 0; i < 6; i++) cyc(0, '0, 0, 0, 1, 1);

    // R5: write barrier, inner
    for (int i = 0; i < 2; i++) cyc(0, '0, 0, 1, 0, 0);
    cyc(1, bw(4'b1010), 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, 1, 0, 0);
    // R9: second barrier held off
    cyc(1, bw(4'b0011), 0, 1, 0, 1);
    cyc(1, bw(4'b0011), 0, 1, 0, 1);
    cyc(1, bw(4'b0011), 1, 1, 1, 0);
    for (int i = 0; i < 6; i++) cyc(0, '0, 1, 1, 1, 1);
    for (int i = 0; i < 8; i++) cyc(0, '0, 0, 0, 1, 1);

    // R6: all-class barrier, full system
    cyc(0, '0, 1, 1, 0, 0);
    cyc(1, bw(4'b1111), 0, 0, 0, 0);
    cyc(0, '0, 1, 1, 1, 0);
    cyc(0, '0, 1, 1, 0, 0);
    cyc(0, '0, 1, 1, 0, 1);
    cyc(0, '0, 1, 1, 0, 0);
    idle(2);

    // R3: reserved options with nothing outstanding
    for (int i = 0; i < 3; i++) cyc(0, '0, 0, 0, 1, 1);
    cyc(1, bw(4'b0100), 0, 0, 0, 0);
    cyc(0, '0, 0, 0, 0, 0);
    cyc(1, bw(4'b1000), 0, 0, 0, 0);
    cyc(1, bw(4'b0001), 0, 0, 0, 0);
    cyc(1, bw(4'b1001), 0, 0, 0, 0);
    cyc(1, bw(4'b0110), 0, 0, 0, 0);
    cyc(1, bw(4'b1101), 0, 0, 0, 0);
    idle(2);

    // R1: near-miss words have no effect
    cyc(0, '0, 1, 1, 0, 0);
    cyc(1, bw(4'b1111) & ~32'h80, 1, 1, 0, 0);
    cyc(1, bw(4'b1111) ^ 32'h1000, 1, 1, 0, 0);
    cyc(1, bw(4'b1111) ^ 32'h40, 1, 1, 0, 0);
    cyc(0, bw(4'b1111), 1, 1, 0, 0);
    idle(1);

    // R7: fill to the cap, completions at zero
    for (int i = 0; i < 20; i++) cyc(0, '0, 1, 1, 0, 0);
    cyc(0, '0, 1, 1, 1, 1);
    cyc(0, '0, 1, 1, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, '0, 0, 0, 1, 1);
    cyc(1, bw(4'b1011), 1, 0, 0, 0);
    cyc(0, '0, 1, 1, 0, 0);
    cyc(0, '0, 0, 0, 1, 0);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule